// File: doc/BRIEF.md
# Frame-Synced Serial Word Transmitter

This block turns parallel words into a bit stream on one serial data line. Timing comes from outside: a bit clock and a frame-sync line, both sampled in the system clock domain and synchronous to it. Every falling edge of the bit clock is one bit period. A rising frame sync seen while the block is idle starts a frame. The first data bit then goes out after a programmed delay of 0, 1 or 2 bit periods.

A frame holds one or two phases. Each phase has its own word length and its own number of words. Phase two either follows phase one directly or waits for frame sync to return low, which suits left/right audio framing. Words arrive on a ready/valid input, one word per slot. By default the low word-length bits go out MSB first. A mode for 32-bit words sends them LSB first instead. When no word is waiting at the start of a slot, the previous word goes out again and an underrun pulse is raised.

Top module: `fs_serial_tx`

## Requirements
- R1: While reset is held and right after it, `sdout`, `sdout_en`, `in_ready` and `underrun` are all 0.
- R2: A bit period is one system clock in which `bclk` is sampled low after being sampled high. A frame starts at the bit period where `fsync` is sampled high after being low at the previous bit period, provided the block is idle or is on the last bit period of a frame. With `cfg_delay` = 0 the first data bit is driven in that same bit period.
- R3: With `cfg_delay` = 1 or 2, `sdout_en` stays low for that many bit periods and the first bit follows. The reserved code 3 behaves like 2.
- R4: With `cfg_lsb_first` = 0, each word sends bits `len-1` down to 0. Here `len` is the phase's length in bits (`cfg_len1` or `cfg_len2`). Data bits above `len` have no effect on the line.
- R5: A single-phase frame (`cfg_dual` = 0) ends after `cfg_words1` words. From then on `sdout_en` is 0 and `sdout` keeps the last bit sent. The same holding applies during delay bit periods.
- R6: With `cfg_dual` = 1 and `cfg_ph2_sync` = 0, the first bit of phase two goes out in the bit period right after the last bit of phase one. Phase two sends `cfg_words2` words of `cfg_len2` bits.
- R7: With `cfg_dual` = 1 and `cfg_ph2_sync` = 1, phase two waits until the bit period right after phase one. From then on it watches for the first bit period in which `fsync` is sampled low. That bit period counts as a start for the data delay of R2/R3. `sdout_en` is 0 while waiting.
- R8: With `cfg_lsb_first` = 1 and a 32-bit length, each word sends bit 0 first and bit 31 last.
- R9: If `in_valid` is 0 when a slot begins, the previous word is sent again. `underrun` is high for one clock after that bit period. It stays 0 for slots that get a word.
- R10: `in_ready` is high for exactly one clock at the start of each slot. One word is accepted per slot, in order.
- R11: `sdout` and the rise of `sdout_en` change only in the clock after a falling `bclk` is sampled. They do not change while `bclk` is high.
- R12: A rising `fsync` during a frame is ignored. The frame runs as programmed, and no new frame follows unless a new rising edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | Bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, synchronous to clk |
| cfg_delay | input | 2 | Data delay in bit periods (3 acts as 2) |
| cfg_dual | input | 1 | 1 selects two-phase frames |
| cfg_ph2_sync | input | 1 | 1 makes phase two wait for fsync low |
| cfg_lsb_first | input | 1 | 1 sends words LSB first (32-bit length) |
| cfg_len1 | input | LEN_W | Phase-one word length in bits |
| cfg_len2 | input | LEN_W | Phase-two word length in bits |
| cfg_words1 | input | CNT_W | Words in phase one (at least 1) |
| cfg_words2 | input | CNT_W | Words in phase two (at least 1) |
| in_valid | input | 1 | A word is offered |
| in_data | input | DATA_W | Offered word |
| in_ready | output | 1 | Word accepted at the coming clock edge |
| sdout | output | 1 | Serial data |
| sdout_en | output | 1 | High while a data bit is on sdout |
| underrun | output | 1 | One-clock pulse when a word was repeated |

## Verification
Each result lands in the clock edge that first samples `bclk` low after it was high. `sdout`, `sdout_en` and `underrun` are registered there. `in_ready` is combinational in the clock just before that edge. The bench lowers `bclk` and sets `fsync` on a falling clock edge and notes any handshake one time step later. It reads the outputs on the next falling clock edge, and reads `sdout` again after `bclk` rises to show it has not moved. Expected bit streams come from the bench's own model of each bit period: delay count, word order and bit order.

// File: rtl/fs_serial_tx.sv
module fs_serial_tx #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  localparam int LEN_W = $clog2(DATA_W + 1),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic [1:0]        cfg_delay,
  input  logic              cfg_dual,
  input  logic              cfg_ph2_sync,
  input  logic              cfg_lsb_first,
  input  logic [LEN_W-1:0]  cfg_len1,
  input  logic [LEN_W-1:0]  cfg_len2,
  input  logic [CNT_W-1:0]  cfg_words1,
  input  logic [CNT_W-1:0]  cfg_words2,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              sdout,
  output logic              sdout_en,
  output logic              underrun
);

  typedef enum logic [1:0] {S_IDLE, S_DLY, S_SHIFT, S_WAIT} state_t;

  state_t            st;
  logic              bclk_q, fs_prev, phase;
  logic [1:0]        dcnt;
  logic [LEN_W-1:0]  bcnt;
  logic [CNT_W-1:0]  wcnt;
  logic [IDX_W-1:0]  bidx;
  logic [DATA_W-1:0] word;

  logic              tick, fs_rise, sh_end, p1_end, frame_end;
  logic              begin1, begin2, begin_any, slot_go, first_slot, nx_phase;
  logic [1:0]        dly_eff;
  logic [LEN_W-1:0]  cur_len;
  logic [CNT_W-1:0]  cur_cnt;
  logic [IDX_W-1:0]  start_idx, nx_idx;
  logic [DATA_W-1:0] word_sel;

  assign tick      = bclk_q & ~bclk;
  assign fs_rise   = fsync & ~fs_prev;
  assign dly_eff   = (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;

  assign sh_end    = (st == S_SHIFT) && (bcnt == '0);
  assign p1_end    = sh_end && (wcnt == '0) && !phase && cfg_dual;
  assign frame_end = sh_end && (wcnt == '0) && (phase || !cfg_dual);

  assign begin1    = ((st == S_IDLE) || frame_end) && fs_rise;
  assign begin2    = cfg_ph2_sync && !fsync && ((st == S_WAIT) || p1_end);
  assign begin_any = begin1 || begin2;

  assign slot_go = tick && ((begin_any && dly_eff == 2'd0) ||
                            ((st == S_DLY) && dcnt == 2'd0) ||
                            (sh_end && wcnt != '0) ||
                            (p1_end && !cfg_ph2_sync));

  always_comb begin
    if (begin1)                nx_phase = 1'b0;
    else if (begin2 || p1_end) nx_phase = 1'b1;
    else                       nx_phase = phase;
  end

  assign first_slot = begin_any || p1_end || (st == S_DLY);
  assign cur_len    = nx_phase ? cfg_len2   : cfg_len1;
  assign cur_cnt    = nx_phase ? cfg_words2 : cfg_words1;
  assign start_idx  = cfg_lsb_first ? '0 : IDX_W'(cur_len - LEN_W'(1));
  assign nx_idx     = cfg_lsb_first ? bidx + IDX_W'(1) : bidx - IDX_W'(1);
  assign word_sel   = in_valid ? in_data : word;
  assign in_ready   = slot_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bclk_q   <= 1'b0;
      fs_prev  <= 1'b0;
      phase    <= 1'b0;
      dcnt     <= '0;
      bcnt     <= '0;
      wcnt     <= '0;
      bidx     <= '0;
      word     <= '0;
      sdout    <= 1'b0;
      sdout_en <= 1'b0;
      underrun <= 1'b0;
    end else begin
      bclk_q   <= bclk;
      underrun <= slot_go && !in_valid;
      if (tick) begin
        fs_prev <= fsync;
        if (slot_go) begin
          st       <= S_SHIFT;
          phase    <= nx_phase;
          word     <= word_sel;
          bidx     <= start_idx;
          sdout    <= word_sel[start_idx];
          sdout_en <= 1'b1;
          bcnt     <= cur_len - LEN_W'(1);
          wcnt     <= first_slot ? cur_cnt - CNT_W'(1) : wcnt - CNT_W'(1);
        end else if (begin_any) begin
          st       <= S_DLY;
          phase    <= nx_phase;
          dcnt     <= dly_eff - 2'd1;
          sdout_en <= 1'b0;
        end else if (st == S_DLY) begin
          dcnt <= dcnt - 2'd1;
        end else if (st == S_SHIFT) begin
          if (bcnt == '0) begin
            st       <= frame_end ? S_IDLE : S_WAIT;
            sdout_en <= 1'b0;
          end else begin
            bidx  <= nx_idx;
            sdout <= word[nx_idx];
            bcnt  <= bcnt - LEN_W'(1);
          end
        end
      end
    end
  end

  // R11
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(bclk_q && !bclk));

  // R11
  en_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdout_en) |-> $past(bclk_q && !bclk));

  // R5
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdout_en && !$past(sdout_en)) |-> $stable(sdout));

  // R3
  delay_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DLY) |-> (dcnt <= 2'd1));

  // R10
  ready_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> sdout_en);

  // R9
  fed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !underrun);

endmodule

// File: tb/fs_serial_tx_test.sv
module fs_serial_tx_test;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int LEN_W  = $clog2(DATA_W + 1);

  logic clk = 1'b0;
  logic rst_n, bclk, fsync;
  logic [1:0] cfg_delay;
  logic cfg_dual, cfg_ph2_sync, cfg_lsb_first;
  logic [LEN_W-1:0] cfg_len1, cfg_len2;
  logic [CNT_W-1:0] cfg_words1, cfg_words2;
  logic in_valid;
  logic [DATA_W-1:0] in_data;
  logic in_ready, sdout, sdout_en, underrun;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] q [0:7];
  int qn, qi;
  logic got_d [0:63];
  logic got_d2 [0:63];
  logic got_en [0:63];
  logic got_u [0:63];

  always #(CLK_P/2) clk = ~clk;

  fs_serial_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .cfg_delay(cfg_delay), .cfg_dual(cfg_dual), .cfg_ph2_sync(cfg_ph2_sync),
    .cfg_lsb_first(cfg_lsb_first), .cfg_len1(cfg_len1), .cfg_len2(cfg_len2),
    .cfg_words1(cfg_words1), .cfg_words2(cfg_words2), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .sdout(sdout),
    .sdout_en(sdout_en), .underrun(underrun));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic feed_update();
    in_valid = (qi < qn);
    in_data  = (qi < 8) ? q[qi] : '0;
  endtask

  task automatic setup(input logic [1:0] dly, input logic dual, input logic sync,
                       input logic lsb, input int l1, input int w1, input int l2, input int w2);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b1; fsync = 1'b0;
    cfg_delay = dly; cfg_dual = dual; cfg_ph2_sync = sync; cfg_lsb_first = lsb;
    cfg_len1 = LEN_W'(l1); cfg_len2 = LEN_W'(l2);
    cfg_words1 = CNT_W'(w1); cfg_words2 = CNT_W'(w2);
    qi = 0;
    feed_update();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_ticks(input int n, input logic [63:0] fs_pat);
    for (int t = 0; t < n; t++) begin
      logic took;
      @(negedge clk);
      bclk = 1'b0; fsync = fs_pat[t];
      #1 took = in_ready && in_valid;
      @(negedge clk);
      got_d[t] = sdout; got_en[t] = sdout_en; got_u[t] = underrun;
      if (took) begin qi++; feed_update(); end
      @(negedge clk);
      bclk = 1'b1;
      @(negedge clk);
      got_d2[t] = sdout;
    end
  endtask

  task automatic exp_word(input string req, input int t0, input logic [31:0] w,
                          input int len, input bit lsb);
    for (int i = 0; i < len; i++) begin
      int b;
      b = lsb ? i : len - 1 - i;
      chk(req, $sformatf("en@%0d", t0 + i), got_en[t0 + i], 1'b1);
      chk(req, $sformatf("bit@%0d", t0 + i), got_d[t0 + i], w[b]);
    end
  endtask

  task automatic exp_off(input string req, input int t, input logic d);
    chk(req, $sformatf("en_off@%0d", t), got_en[t], 1'b0);
    chk(req, $sformatf("hold@%0d", t), got_d[t], d);
  endtask

  task automatic t_reset();
    setup(2'd0, 1'b0, 1'b0, 1'b0, 8, 1, 8, 1);
    chk("R1", "sdout", sdout, 1'b0);
    chk("R1", "sdout_en", sdout_en, 1'b0);
    chk("R1", "in_ready", in_ready, 1'b0);
    chk("R1", "underrun", underrun, 1'b0);
  endtask

  task automatic t_single();
    q[0] = 32'h1234_56A5; q[1] = 32'hFFFF_FF3D; qn = 2;
    setup(2'd0, 1'b0, 1'b0, 1'b0, 8, 2, 8, 1);
    run_ticks(18, 64'h1);
    exp_word("R2", 0, 32'hA5, 8, 0);
    exp_word("R4", 8, 32'h3D, 8, 0);
    exp_off("R5", 16, 1'b1);
    exp_off("R5", 17, 1'b1);
    chk_int("R10", "words taken", qi, 2);
    chk("R9", "no underrun slot0", got_u[0], 1'b0);
    chk("R9", "no underrun slot1", got_u[8], 1'b0);
    for (int t = 0; t < 16; t++)
      chk("R11", $sformatf("stable while bclk high @%0d", t), got_d2[t], got_d[t]);
  endtask

  task automatic t_delay(input logic [1:0] code, input int eff);
    q[0] = 32'hFFFF_FFF9; qn = 1;
    setup(code, 1'b0, 1'b0, 1'b0, 4, 1, 4, 1);
    run_ticks(eff + 6, 64'h1);
    for (int t = 0; t < eff; t++) exp_off("R3", t, 1'b0);
    exp_word("R3", eff, 32'h9, 4, 0);
    exp_off("R5", eff + 4, 1'b1);
  endtask

  task automatic t_dual_free();
    q[0] = 32'h5; q[1] = 32'h2D; q[2] = 32'h13; qn = 3;
    setup(2'd0, 1'b1, 1'b0, 1'b0, 4, 1, 6, 2);
    run_ticks(17, 64'h1);
    exp_word("R6", 0, 32'h5, 4, 0);
    exp_word("R6", 4, 32'h2D, 6, 0);
    exp_word("R6", 10, 32'h13, 6, 0);
    exp_off("R6", 16, 1'b1);
  endtask

  task automatic t_dual_sync();
    q[0] = 32'hC; q[1] = 32'h6; qn = 2;
    setup(2'd1, 1'b1, 1'b1, 1'b0, 4, 1, 4, 1);
    run_ticks(12, 64'h3F);
    exp_off("R3", 0, 1'b0);
    exp_word("R7", 1, 32'hC, 4, 0);
    exp_off("R7", 5, 1'b0);
    exp_off("R7", 6, 1'b0);
    exp_word("R7", 7, 32'h6, 4, 0);
    exp_off("R7", 11, 1'b0);
  endtask

  task automatic t_lsb();
    q[0] = 32'h8000_00F1; qn = 1;
    setup(2'd0, 1'b0, 1'b0, 1'b1, 32, 1, 32, 1);
    run_ticks(33, 64'h1);
    exp_word("R8", 0, 32'h8000_00F1, 32, 1);
    exp_off("R8", 32, 1'b1);
  endtask

  task automatic t_underrun();
    q[0] = 32'hA; qn = 1;
    setup(2'd0, 1'b0, 1'b0, 1'b0, 4, 2, 4, 1);
    run_ticks(9, 64'h1);
    exp_word("R9", 0, 32'hA, 4, 0);
    exp_word("R9", 4, 32'hA, 4, 0);
    chk("R9", "underrun first slot", got_u[0], 1'b0);
    chk("R9", "underrun repeat slot", got_u[4], 1'b1);
    chk("R9", "underrun one clock", got_u[5], 1'b0);
  endtask

  task automatic t_ignore();
    q[0] = 32'h81; q[1] = 32'h7E; qn = 2;
    setup(2'd0, 1'b0, 1'b0, 1'b0, 8, 1, 8, 1);
    run_ticks(12, 64'h9);
    exp_word("R12", 0, 32'h81, 8, 0);
    for (int t = 8; t < 12; t++) exp_off("R12", t, 1'b1);
    chk_int("R12", "words taken", qi, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b1; fsync = 1'b0;
    qn = 0; qi = 0;
    for (int i = 0; i < 8; i++) q[i] = '0;
    feed_update();
    t_reset();
    t_single();
    t_delay(2'd1, 1);
    t_delay(2'd2, 2);
    t_delay(2'd3, 2);
    t_dual_free();
    t_dual_sync();
    t_lsb();
    t_underrun();
    t_ignore();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule